// File: doc/BRIEF.md
# Vector Loop State Register Controller

This block holds the 64-bit word that describes a vector loop in progress: the maximum and current vector lengths, the source and destination element positions, the sub-element positions, per-operand remap selectors and enables, pack and unpack ordering flags, a parallelism hint, a remap-persistence flag and a vertical-first flag. A second 64-bit link register sits beside it. The word can be exchanged with the link register in a single cycle, for example around a call or a vectorised branch.

Three operations change the word. A set-length operation loads the maximum length from an immediate and sets the vector length to the smaller of a requested length and that maximum. The requested length comes from an immediate, a register operand or a counter value. The same length is returned as the operation's result. A full-word write loads every field at once, clamps the length and clears the reserved bits. A swap exchanges the word with the link register. An out-of-range setting is not committed. Instead the block enters a one-cycle trap state and pulses its illegal-instruction output.

A two-state machine tracks traps. In ST_READY no trap is pending. The transition READY_TO_TRAP fires when the operation just presented is illegal. In ST_TRAP the trap output is high. From ST_TRAP, the transition TRAP_TO_TRAP fires on another illegal operation and TRAP_TO_READY fires on anything else. Operations presented while in ST_TRAP are handled exactly as in ST_READY.

Top module: `vstate_ctrl`

## Requirements
- R1: Field positions in `state_o` (bit 63 is the most significant) are fixed as follows.
  - Lengths and positions: maxvl [63:57], vl [56:50], srcstep [49:43], dststep [42:36], dsubstep [35:34], ssubstep [33:32].
  - Remap controls: five 2-bit selectors in [31:22], operand 0 in [31:30] down to operand 4 in [23:22]; enable bits [21:17], with bit 17 for operand 0 and bit 21 for operand 4.
  - Reserved bits are [16:11].
  - Flags and hint: pack [10], unpack [9], hphint [8:2], rmpst [1], vfirst [0].
  - The field outputs mirror these fields.
- R2: A legal set-length operation stores vl = MIN(vlen, maxvl). The comparison uses the full 64-bit vlen. `vl_result_o` shows the stored length from the next cycle on.
- R3: `sl_src_i` selects vlen: 0 selects the 7-bit immediate, 1 the register operand, 2 the counter value, and 3 the immediate.
- R4: A legal set-length operation loads maxvl from `sl_mvl_i` and zeroes srcstep, dststep, dsubstep and ssubstep. It leaves the selectors, enables, pack, unpack, hphint and vfirst unchanged.
- R5: A legal full-word write stores every field, except that vl is replaced by maxvl when it exceeds maxvl.
- R6: The following operations are illegal:
  - a set-length operation with `sl_mvl_i` above 64;
  - a full-word write with srcstep or dststep at 64 or above, or with vl or maxvl above 64.
  An illegal operation leaves both registers unchanged.
- R7: A set-length operation that changes vl or maxvl clears rmpst. One that leaves both unchanged keeps rmpst.
- R8: The reserved bits [16:11] of the state word are always zero, whatever a write supplies.
- R9: `remap_active_o` is high exactly when any enable bit is set. In `op_sel_o`, operand i occupies bits [2i+1:2i]. Each pair shows that operand's selector when its enable bit is set and 0 otherwise. Operand 0 is RA and operand 4 is EA.
- R10: A swap (`op_i`=3) exchanges the state word and the link register in one cycle.
- R11: After reset, the state word and the link register are 0 and `trap_o` is low.
- R12: `trap_o` is high for exactly the cycle after each illegal operation. It stays high across back-to-back illegal operations and falls after a legal or idle one. `op_i` codes: 0 idle, 1 set-length, 2 full-word write, 3 swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| op_i | input | 2 | Operation code |
| sl_mvl_i | input | 7 | Set-length maximum-length immediate |
| sl_src_i | input | 2 | Set-length vlen source select |
| sl_imm_i | input | 7 | Set-length vlen immediate |
| sl_reg_i | input | 64 | Set-length vlen register operand |
| sl_ctr_i | input | 64 | Set-length vlen counter value |
| wr_data_i | input | 64 | Full-word write data |
| state_o | output | 64 | State word |
| link_o | output | 64 | Link register |
| maxvl_o | output | 7 | Maximum vector length |
| vl_o | output | 7 | Vector length |
| srcstep_o | output | 7 | Source element position |
| dststep_o | output | 7 | Destination element position |
| dsubstep_o | output | 2 | Destination sub-element position |
| ssubstep_o | output | 2 | Source sub-element position |
| hphint_o | output | 7 | Parallelism hint |
| pack_o | output | 1 | Pack ordering flag |
| unpack_o | output | 1 | Unpack ordering flag |
| rmpst_o | output | 1 | Remap persistence flag |
| vfirst_o | output | 1 | Vertical-first flag |
| remap_active_o | output | 1 | Any remap enable set |
| op_sel_o | output | 10 | Gated per-operand selectors |
| vl_result_o | output | 7 | Length returned by the last legal set-length |
| trap_o | output | 1 | Illegal-instruction trap pulse |

## Verification
Two things can happen in the same cycle in this block: the length clamp of a set-length operation and the clearing of the persistence flag. The bench sets rmpst with a full-word write. It then issues a set-length whose vlen exceeds the new maximum, and another whose maximum changes while vl stays the same. It judges each result by comparing the whole state word, so the clamped length, the zeroed positions and the cleared or kept flag are all checked together. Back-to-back illegal operations also put a trap pulse and a held state in one cycle; these are judged on `trap_o` and `state_o` together.

// File: rtl/vstate_pkg.sv
package vstate_pkg;
    localparam int WORD_W    = 64;
    localparam int LEN_W     = 7;
    localparam int LEN_LIMIT = 64;
    localparam int SUB_W     = 2;
    localparam int SEL_W     = 2;
    localparam int NOPS      = 5;
    localparam int RSVD_W    = 6;
    localparam int VLEN_W    = 64;

    // first member is the most significant bit of the word
    typedef struct packed {
        logic [LEN_W-1:0]  maxvl;
        logic [LEN_W-1:0]  vl;
        logic [LEN_W-1:0]  srcstep;
        logic [LEN_W-1:0]  dststep;
        logic [SUB_W-1:0]  dsub;
        logic [SUB_W-1:0]  ssub;
        logic [SEL_W-1:0]  sel0;
        logic [SEL_W-1:0]  sel1;
        logic [SEL_W-1:0]  sel2;
        logic [SEL_W-1:0]  sel3;
        logic [SEL_W-1:0]  sel4;
        logic [NOPS-1:0]   enable;
        logic [RSVD_W-1:0] rsvd;
        logic              pack;
        logic              unpack;
        logic [LEN_W-1:0]  hphint;
        logic              rmpst;
        logic              vfirst;
    } vstate_t;

    typedef enum logic [1:0] {OP_IDLE, OP_SETLEN, OP_WRITE, OP_SWAP} op_e;
    typedef enum logic [1:0] {SRC_IMM, SRC_REG, SRC_CTR, SRC_IMM_ALT} vsrc_e;
    typedef enum logic {ST_READY, ST_TRAP} st_e;
endpackage

// File: rtl/vstate_setlen.sv
module vstate_setlen
    import vstate_pkg::*;
(
    input  vstate_t            cur_i,
    input  logic [LEN_W-1:0]   mvl_i,
    input  logic [VLEN_W-1:0]  vlen_i,
    output vstate_t            nxt_o,
    output logic [LEN_W-1:0]   vl_o,
    output logic               bad_o
);
    localparam int PAD_W = VLEN_W - LEN_W;

    logic [VLEN_W-1:0] mvl_wide;
    logic              changed;

    assign mvl_wide = {{PAD_W{1'b0}}, mvl_i};
    assign vl_o     = (vlen_i > mvl_wide) ? mvl_i : vlen_i[LEN_W-1:0];
    assign bad_o    = mvl_i > LEN_W'(LEN_LIMIT);
    assign changed  = (vl_o != cur_i.vl) || (mvl_i != cur_i.maxvl);

    always_comb begin
        nxt_o         = cur_i;
        nxt_o.maxvl   = mvl_i;
        nxt_o.vl      = vl_o;
        nxt_o.srcstep = '0;
        nxt_o.dststep = '0;
        nxt_o.dsub    = '0;
        nxt_o.ssub    = '0;
        nxt_o.rsvd    = '0;
        nxt_o.rmpst   = changed ? 1'b0 : cur_i.rmpst;
    end

    always_comb begin
        AST_LEN_CLAMP: assert (vl_o <= mvl_i); // R2
    end
endmodule

// File: rtl/vstate_sanitize.sv
module vstate_sanitize
    import vstate_pkg::*;
(
    input  vstate_t raw_i,
    output vstate_t clean_o,
    output logic    bad_o
);
    always_comb begin
        bad_o = (raw_i.srcstep >= LEN_W'(LEN_LIMIT))
             || (raw_i.dststep >= LEN_W'(LEN_LIMIT))
             || (raw_i.vl      >  LEN_W'(LEN_LIMIT))
             || (raw_i.maxvl   >  LEN_W'(LEN_LIMIT));
        clean_o      = raw_i;
        clean_o.rsvd = '0;
        if (raw_i.vl > raw_i.maxvl)
            clean_o.vl = raw_i.maxvl;
    end

    always_comb begin
        AST_CLEAN_RSVD: assert (clean_o.rsvd == '0); // R8
    end
endmodule

// File: rtl/vstate_ctrl.sv
module vstate_ctrl
    import vstate_pkg::*;
(
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [1:0]              op_i,
    input  logic [LEN_W-1:0]        sl_mvl_i,
    input  logic [1:0]              sl_src_i,
    input  logic [LEN_W-1:0]        sl_imm_i,
    input  logic [VLEN_W-1:0]       sl_reg_i,
    input  logic [VLEN_W-1:0]       sl_ctr_i,
    input  logic [WORD_W-1:0]       wr_data_i,
    output logic [WORD_W-1:0]       state_o,
    output logic [WORD_W-1:0]       link_o,
    output logic [LEN_W-1:0]        maxvl_o,
    output logic [LEN_W-1:0]        vl_o,
    output logic [LEN_W-1:0]        srcstep_o,
    output logic [LEN_W-1:0]        dststep_o,
    output logic [SUB_W-1:0]        dsubstep_o,
    output logic [SUB_W-1:0]        ssubstep_o,
    output logic [LEN_W-1:0]        hphint_o,
    output logic                    pack_o,
    output logic                    unpack_o,
    output logic                    rmpst_o,
    output logic                    vfirst_o,
    output logic                    remap_active_o,
    output logic [NOPS*SEL_W-1:0]   op_sel_o,
    output logic [LEN_W-1:0]        vl_result_o,
    output logic                    trap_o
);
    localparam int IMM_PAD = VLEN_W - LEN_W;

    vstate_t           state_q, link_q, sl_next, wr_next;
    st_e               st_q, st_d;
    op_e               op;
    vsrc_e             src;
    logic [VLEN_W-1:0] vlen;
    logic [LEN_W-1:0]  sl_vl, vl_res_q;
    logic              sl_bad, wr_bad, illegal;
    logic [SEL_W-1:0]  sel_arr [NOPS];

    assign op  = op_e'(op_i);
    assign src = vsrc_e'(sl_src_i);

    always_comb begin
        unique case (src)
            SRC_REG:     vlen = sl_reg_i;
            SRC_CTR:     vlen = sl_ctr_i;
            SRC_IMM,
            SRC_IMM_ALT: vlen = {{IMM_PAD{1'b0}}, sl_imm_i};
        endcase
    end

    vstate_setlen u_setlen (
        .cur_i  (state_q),
        .mvl_i  (sl_mvl_i),
        .vlen_i (vlen),
        .nxt_o  (sl_next),
        .vl_o   (sl_vl),
        .bad_o  (sl_bad)
    );

    vstate_sanitize u_sanitize (
        .raw_i   (vstate_t'(wr_data_i)),
        .clean_o (wr_next),
        .bad_o   (wr_bad)
    );

    assign illegal = ((op == OP_SETLEN) && sl_bad) || ((op == OP_WRITE) && wr_bad);

    // trap state machine: next-state logic
    always_comb begin
        unique case (st_q)
            ST_READY: st_d = illegal ? ST_TRAP : ST_READY;  // READY_TO_TRAP
            ST_TRAP:  st_d = illegal ? ST_TRAP : ST_READY;  // TRAP_TO_TRAP / TRAP_TO_READY
        endcase
    end

    // trap state machine: state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= ST_READY;
        else         st_q <= st_d;
    end

    // trap state machine: outputs
    always_comb begin
        unique case (st_q)
            ST_READY: trap_o = 1'b0;
            ST_TRAP:  trap_o = 1'b1;
        endcase
    end

    // state and link registers
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q  <= '0;
            link_q   <= '0;
            vl_res_q <= '0;
        end else if (!illegal) begin
            unique case (op)
                OP_SETLEN: begin
                    state_q  <= sl_next;
                    vl_res_q <= sl_vl;
                end
                OP_WRITE: state_q <= wr_next;
                OP_SWAP: begin
                    state_q <= link_q;
                    link_q  <= state_q;
                end
                OP_IDLE: ;
            endcase
        end
    end

    assign sel_arr[0] = state_q.sel0;
    assign sel_arr[1] = state_q.sel1;
    assign sel_arr[2] = state_q.sel2;
    assign sel_arr[3] = state_q.sel3;
    assign sel_arr[4] = state_q.sel4;

    for (genvar i = 0; i < NOPS; i++) begin : g_opsel
        assign op_sel_o[i*SEL_W +: SEL_W] = state_q.enable[i] ? sel_arr[i] : '0;
    end

    assign remap_active_o = |state_q.enable;
    assign state_o        = state_q;
    assign link_o         = link_q;
    assign maxvl_o        = state_q.maxvl;
    assign vl_o           = state_q.vl;
    assign srcstep_o      = state_q.srcstep;
    assign dststep_o      = state_q.dststep;
    assign dsubstep_o     = state_q.dsub;
    assign ssubstep_o     = state_q.ssub;
    assign hphint_o       = state_q.hphint;
    assign pack_o         = state_q.pack;
    assign unpack_o       = state_q.unpack;
    assign rmpst_o        = state_q.rmpst;
    assign vfirst_o       = state_q.vfirst;
    assign vl_result_o    = vl_res_q;

    AST_VL_WITHIN_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_q.vl <= state_q.maxvl); // R5
    AST_RSVD_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_q.rsvd == '0); // R8
    AST_TRAP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_o |-> ($stable(state_q) && $stable(link_q))); // R6
    AST_STEP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q.srcstep < LEN_W'(LEN_LIMIT)) && (state_q.dststep < LEN_W'(LEN_LIMIT))
        && (state_q.maxvl <= LEN_W'(LEN_LIMIT))); // R6
    AST_SWAP_XCHG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op == OP_SWAP) |=> ((state_q == $past(link_q)) && (link_q == $past(state_q)))); // R10
    AST_RMPST_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((op == OP_SETLEN) && !sl_bad && ((sl_vl != state_q.vl) || (sl_mvl_i != state_q.maxvl)))
        |=> !state_q.rmpst); // R7
    AST_TRAP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        illegal |=> trap_o); // R12
endmodule

// File: tb/vstate_ctrl_tb.sv
`timescale 1ns/1ps
module vstate_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [6:0]  sl_mvl = '0;
    logic [1:0]  sl_src = '0;
    logic [6:0]  sl_imm = '0;
    logic [63:0] sl_reg = '0;
    logic [63:0] sl_ctr = '0;
    logic [63:0] wr_data = '0;
    logic [63:0] state, link;
    logic [6:0]  maxvl, vl, srcstep, dststep, hphint, vl_res;
    logic [1:0]  dsub, ssub;
    logic        pack, unpack, rmpst, vfirst, remap_act, trap;
    logic [9:0]  op_sel;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    vstate_ctrl u_dut (
        .clk_i(clk), .rst_ni(rst_n), .op_i(op), .sl_mvl_i(sl_mvl), .sl_src_i(sl_src),
        .sl_imm_i(sl_imm), .sl_reg_i(sl_reg), .sl_ctr_i(sl_ctr), .wr_data_i(wr_data),
        .state_o(state), .link_o(link), .maxvl_o(maxvl), .vl_o(vl), .srcstep_o(srcstep),
        .dststep_o(dststep), .dsubstep_o(dsub), .ssubstep_o(ssub), .hphint_o(hphint),
        .pack_o(pack), .unpack_o(unpack), .rmpst_o(rmpst), .vfirst_o(vfirst),
        .remap_active_o(remap_act), .op_sel_o(op_sel), .vl_result_o(vl_res), .trap_o(trap)
    );

    function automatic logic [63:0] mk(input logic [6:0] mv, input logic [6:0] v,
        input logic [6:0] s, input logic [6:0] d, input logic [1:0] ds, input logic [1:0] ss,
        input logic [9:0] sel, input logic [4:0] en, input logic [5:0] rs, input logic pk,
        input logic up, input logic [6:0] hp, input logic rm, input logic vf);
        return {mv, v, s, d, ds, ss, sel, en, rs, pk, up, hp, rm, vf};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
        chk(act === exp, tag, act, exp);
    endtask

    // present one operation at a negedge, return at the following negedge
    task automatic setlen(input logic [6:0] mv, input logic [1:0] sel, input logic [63:0] vlen);
        sl_mvl = mv; sl_src = sel;
        sl_imm = (sel == 2'd0 || sel == 2'd3) ? vlen[6:0] : 7'd9;
        sl_reg = (sel == 2'd1) ? vlen : 64'd9;
        sl_ctr = (sel == 2'd2) ? vlen : 64'd9;
        op = 2'd1;
        @(negedge clk);
        op = 2'd0;
    endtask

    task automatic wr(input logic [63:0] w);
        wr_data = w; op = 2'd2;
        @(negedge clk);
        op = 2'd0;
    endtask

    task automatic swap();
        op = 2'd3;
        @(negedge clk);
        op = 2'd0;
    endtask

    typedef struct packed {
        logic [6:0]  mvl;
        logic [1:0]  sel;
        logic [63:0] vlen;
        logic [6:0]  emvl;
        logic [6:0]  evl;
        logic        etrap;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{7'd10,  2'd0, 64'd4,            7'd10, 7'd4,  1'b0},
        '{7'd10,  2'd1, 64'd20,           7'd10, 7'd10, 1'b0},
        '{7'd64,  2'd2, 64'd64,           7'd64, 7'd64, 1'b0},
        '{7'd65,  2'd0, 64'd1,            7'd64, 7'd64, 1'b1},
        '{7'd127, 2'd1, 64'd0,            7'd64, 7'd64, 1'b1},
        '{7'd0,   2'd2, 64'd5,            7'd0,  7'd0,  1'b0},
        '{7'd32,  2'd1, 64'h1_0000_0003,  7'd32, 7'd32, 1'b0},
        '{7'd32,  2'd3, 64'd0,            7'd32, 7'd0,  1'b0}
    };

    initial begin
        logic [63:0] w, e, a;
        repeat (3) @(negedge clk);
        chk_eq("R11 state after reset", state, 64'd0);
        chk_eq("R11 link after reset", link, 64'd0);
        chk_eq("R11 trap after reset", {63'd0, trap}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // table: set-length vectors (R2 R3 R4 R6 R12)
        for (int i = 0; i < NV; i++) begin
            setlen(VEC[i].mvl, VEC[i].sel, VEC[i].vlen);
            chk_eq($sformatf("R2 maxvl row %0d", i), {57'd0, maxvl}, {57'd0, VEC[i].emvl});
            chk_eq($sformatf("R3 vl row %0d", i), {57'd0, vl}, {57'd0, VEC[i].evl});
            chk_eq($sformatf("R12 trap row %0d", i), {63'd0, trap}, {63'd0, VEC[i].etrap});
            if (!VEC[i].etrap)
                chk_eq($sformatf("R2 result row %0d", i), {57'd0, vl_res}, {57'd0, VEC[i].evl});
        end

        // full write: clamp, reserved clear, field outputs (R1 R5 R8 R9)
        w = mk(7'd20, 7'd30, 7'd5, 7'd6, 2'd2, 2'd1, 10'h1B1, 5'd0, 6'h3F, 1'b1, 1'b0, 7'd100, 1'b1, 1'b1);
        e = mk(7'd20, 7'd20, 7'd5, 7'd6, 2'd2, 2'd1, 10'h1B1, 5'd0, 6'h00, 1'b1, 1'b0, 7'd100, 1'b1, 1'b1);
        wr(w);
        chk_eq("R5 R8 write clamp and reserved", state, e);
        chk_eq("R1 vl at [56:50]", {57'd0, vl}, {57'd0, state[56:50]});
        chk_eq("R1 field outputs", {srcstep, dststep, dsub, ssub, hphint, pack, unpack, rmpst, vfirst},
               {7'd5, 7'd6, 2'd2, 2'd1, 7'd100, 1'b1, 1'b0, 1'b1, 1'b1});
        chk_eq("R9 enables zero: inactive", {53'd0, remap_act, op_sel}, 64'd0);

        wr(mk(7'd20, 7'd4, 7'd0, 7'd0, 2'd0, 2'd0, 10'h1B1, 5'b00001, 6'd0, 1'b0, 1'b0, 7'd0, 1'b0, 1'b0));
        chk_eq("R9 RA only", {53'd0, remap_act, op_sel}, {53'd0, 1'b1, 10'h001});
        wr(mk(7'd20, 7'd4, 7'd0, 7'd0, 2'd0, 2'd0, 10'h1B1, 5'b10000, 6'd0, 1'b0, 1'b0, 7'd0, 1'b0, 1'b0));
        chk_eq("R9 EA only", {53'd0, remap_act, op_sel}, {53'd0, 1'b1, 10'h100});
        e = mk(7'd20, 7'd4, 7'd0, 7'd0, 2'd0, 2'd0, 10'h1B1, 5'b11111, 6'd0, 1'b0, 1'b0, 7'd0, 1'b0, 1'b0);
        wr(e);
        chk_eq("R9 all operands", {53'd0, remap_act, op_sel}, {53'd0, 1'b1, 10'h139});

        // illegal writes (R6 R12)
        wr(mk(7'd20, 7'd4, 7'd64, 7'd0, 2'd0, 2'd0, 10'd0, 5'd0, 6'd0, 1'b0, 1'b0, 7'd0, 1'b0, 1'b0));
        chk_eq("R6 srcstep 64 held", state, e);
        chk_eq("R12 srcstep 64 trap", {63'd0, trap}, 64'd1);
        wr(mk(7'd20, 7'd4, 7'd0, 7'd64, 2'd0, 2'd0, 10'd0, 5'd0, 6'd0, 1'b0, 1'b0, 7'd0, 1'b0, 1'b0));
        chk_eq("R6 dststep 64 held", state, e);
        wr(mk(7'd20, 7'd65, 7'd0, 7'd0, 2'd0, 2'd0, 10'd0, 5'd0, 6'd0, 1'b0, 1'b0, 7'd0, 1'b0, 1'b0));
        chk_eq("R6 vl 65 held", state, e);
        wr(mk(7'd65, 7'd1, 7'd0, 7'd0, 2'd0, 2'd0, 10'd0, 5'd0, 6'd0, 1'b0, 1'b0, 7'd0, 1'b0, 1'b0));
        chk_eq("R6 maxvl 65 held", state, e);
        chk_eq("R12 trap stays high", {63'd0, trap}, 64'd1);
        e = mk(7'd64, 7'd64, 7'd63, 7'd63, 2'd3, 2'd3, 10'd0, 5'd0, 6'd0, 1'b0, 1'b0, 7'd0, 1'b0, 1'b0);
        wr(e);
        chk_eq("R6 edge values legal", state, e);
        chk_eq("R12 trap falls", {63'd0, trap}, 64'd0);

        // persistence flag and step zeroing (R4 R7)
        wr(mk(7'd10, 7'd5, 7'd3, 7'd4, 2'd1, 2'd1, 10'h2C3, 5'd3, 6'd0, 1'b1, 1'b1, 7'd8, 1'b1, 1'b1));
        setlen(7'd10, 2'd0, 64'd5);
        chk_eq("R4 R7 same lengths keep rmpst", state,
               mk(7'd10, 7'd5, 7'd0, 7'd0, 2'd0, 2'd0, 10'h2C3, 5'd3, 6'd0, 1'b1, 1'b1, 7'd8, 1'b1, 1'b1));
        setlen(7'd20, 2'd2, 64'd5);
        chk_eq("R7 maxvl change clears rmpst", state,
               mk(7'd20, 7'd5, 7'd0, 7'd0, 2'd0, 2'd0, 10'h2C3, 5'd3, 6'd0, 1'b1, 1'b1, 7'd8, 1'b0, 1'b1));
        wr(mk(7'd10, 7'd5, 7'd3, 7'd4, 2'd1, 2'd1, 10'd0, 5'd0, 6'd0, 1'b0, 1'b0, 7'd0, 1'b1, 1'b0));
        setlen(7'd10, 2'd1, 64'd200);
        chk_eq("R2 R7 clamp and clear together", state,
               mk(7'd10, 7'd10, 7'd0, 7'd0, 2'd0, 2'd0, 10'd0, 5'd0, 6'd0, 1'b0, 1'b0, 7'd0, 1'b0, 1'b0));

        // swap (R10)
        a = mk(7'd40, 7'd33, 7'd7, 7'd9, 2'd1, 2'd2, 10'h155, 5'd9, 6'd0, 1'b1, 1'b0, 7'd60, 1'b1, 1'b0);
        wr(a);
        swap();
        chk_eq("R10 swap state", state, 64'd0);
        chk_eq("R10 swap link", link, a);
        swap();
        chk_eq("R10 swap back state", state, a);
        chk_eq("R10 swap back link", link, 64'd0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R12 watchdog act=running exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule